// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits on the memory side of a host bridge and decides, for every CPU memory access, whether it is served by DRAM or forwarded to the PCI bus. Its main concern is the legacy area below 1 MB. There, a set of byte-wide attribute registers in configuration space gives each shadow region its own read and write steering. A separate control byte handles the 128 KB graphics/SMM window, and accesses made in system-management mode see that window differently from ordinary accesses.

Accesses enter on a valid/ready request channel and leave on a valid/ready decision channel through a single register stage. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high whenever the output stage is empty or the consumer asserts `dec_ready` in the same cycle. While `dec_valid` is high and `dec_ready` is low, the decision is held unchanged and no new request is taken. The route is decided from the configuration state present at the acceptance edge.

Configuration writes arrive as dword-addressed writes with per-byte enables. Only enabled bytes that land on one of the attribute registers or the SMM control byte are stored. The decode always reflects the stored bytes, so any write touching them takes effect for the next accepted access.

Top module: `lma_decoder`

## Requirements
- R1: After reset `dec_valid` is 0, every attribute register is 0x00 and the SMM control byte is 0x02: every shadow-region access and every window access, in either mode, routes to PCI (`dec_to_dram` = 0).
- R2: Region 0 spans 0xF0000..0xFFFFF. Regions 1..12 are 16 KB each, back to back from 0xC0000, so region i starts at 0xC0000 + (i-1)*0x4000.
- R3: Region i takes its field from the attribute byte at configuration offset 0x59 + ceil(i/2). Region 0 and even regions use bits [5:4] of that byte, and odd regions use bits [1:0]. Within a field, the low bit enables reads to DRAM and the high bit enables writes to DRAM.
- R4: In a shadow region, a read routes to DRAM exactly when its read bit is 1, and a write routes to DRAM exactly when its write bit is 1. Otherwise the access routes to PCI.
- R5: A non-SMM access (`req_smm` = 0) in 0xA0000..0xBFFFF routes to DRAM exactly when bit 6 of the SMM control byte (offset 0x72) is 1.
- R6: An SMM access (`req_smm` = 1) in 0xA0000..0xBFFFF routes to DRAM exactly when bit 3 of the SMM control byte is 1.
- R7: Any other address routes to DRAM when it is below `TOP_OF_MEM` and to PCI otherwise. Addresses below 0xA0000 therefore go to DRAM.
- R8: Configuration byte offset = 4*`cfg_dw` + lane. A lane is stored only when its `cfg_be` bit is 1 and its offset is 0x59..0x5F or 0x72. Every other byte, and every disabled lane, leaves the routing unchanged.
- R9: A configuration write changes the route of requests accepted at later edges, not of a request accepted at the same edge.
- R10: `req_ready` = 1 when `dec_valid` = 0 or `dec_ready` = 1. While `dec_valid` = 1 and `dec_ready` = 0, the output stays valid and `dec_to_dram` is stable. An accepted request shows `dec_valid` = 1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for the dword lanes |
| cfg_wdata | input | 32 | Write data, lane n in bits [8n+7:8n] |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request may be accepted |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Access made in system-management mode |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Consumer accepts the decision |
| dec_to_dram | output | 1 | 1 = DRAM, 0 = PCI |

## Verification
Directed cases pair reads with writes in one region whose field enables only one direction. This separates the read bit from the write bit, and the odd-region nibble from the even-region nibble. Window accesses are tried with the open bit and the global-enable bit set one at a time, which shows that each mode follows its own bit. Partial-enable writes to neighbouring bytes show that stray lanes are dropped. A write in the same cycle as a request shows the one-edge apply point. Constrained-random traffic then mixes random configuration bytes with addresses across the window, the shadow regions, low memory and the full 32-bit space, so that region boundaries and the top-of-memory split are crossed many times.

// File: rtl/lma_pkg.sv
package lma_pkg;
  localparam int unsigned NUM_REGIONS = 13;
  localparam int unsigned NUM_ATTR    = 7;
  localparam int unsigned ATTR_BASE   = 'h59;
  localparam int unsigned SMM_OFF     = 'h72;
  localparam logic [7:0]  SMM_RESET   = 8'h02;
  localparam int unsigned OPEN_BIT    = 6;
  localparam int unsigned GEN_BIT     = 3;
  localparam int unsigned BIOS_LO     = 'hF0000;
  localparam int unsigned BIOS_HI     = 'hFFFFF;
  localparam int unsigned EXP_LOG2    = 14;
  localparam int unsigned EXP_BASE    = BIOS_LO - (NUM_REGIONS - 1) * (1 << EXP_LOG2);
  localparam int unsigned WIN_LO      = 'hA0000;
  localparam int unsigned WIN_HI      = 'hBFFFF;
  localparam int unsigned IDX_W       = $clog2(NUM_REGIONS);

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_ATTR  = 2'd1,
    CLS_WIN   = 2'd2
  } addr_cls_e;
endpackage

// File: rtl/lma_cfg_regs.sv
module lma_cfg_regs
  import lma_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [5:0]                    cfg_dw,
  input  logic [3:0]                    cfg_be,
  input  logic [31:0]                   cfg_wdata,
  output logic [NUM_REGIONS-1:0][1:0]   fields,
  output logic                          win_open,
  output logic                          win_gen
);
  // attribute bytes, one register per configuration offset
  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
    localparam logic [7:0] OFF = 8'(ATTR_BASE + k);
    logic [7:0] q;
    logic       hit;
    logic       unused_q;
    assign hit = cfg_wr && (cfg_dw == OFF[7:2]) && cfg_be[OFF[1:0]];
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= 8'h00;
      else if (hit) q <= cfg_wdata[8*OFF[1:0] +: 8];
    end
    assign unused_q = ^{q[7:6], q[3:2]};
  end

  // region field extraction: odd regions low nibble, others high nibble
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_fld
    localparam int RB = (r + 1) / 2;
    localparam int NB = (r % 2 == 1) ? 0 : 4;
    assign fields[r] = g_attr[RB].q[NB +: 2];
  end

  logic unused_low0;
  assign unused_low0 = ^g_attr[0].q[1:0];

  // SMM window control byte
  localparam logic [7:0] SOFF = 8'(SMM_OFF);
  logic [7:0] smm_q;
  logic       smm_hit;
  logic       unused_smm;
  assign smm_hit = cfg_wr && (cfg_dw == SOFF[7:2]) && cfg_be[SOFF[1:0]];
  always_ff @(posedge clk) begin
    if (!rst_n)       smm_q <= SMM_RESET;
    else if (smm_hit) smm_q <= cfg_wdata[8*SOFF[1:0] +: 8];
  end
  assign win_open   = smm_q[OPEN_BIT];
  assign win_gen    = smm_q[GEN_BIT];
  assign unused_smm = ^{smm_q[7], smm_q[5:4], smm_q[2:0]};
endmodule

// File: rtl/lma_region_decode.sv
module lma_region_decode
  import lma_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]  TOP_OF_MEM = 'h0800_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_cls_e         cls,
  output logic [IDX_W-1:0]  idx,
  output logic              below_tom
);
  localparam logic [ADDR_W-1:0] A_BIOS_LO = ADDR_W'(BIOS_LO);
  localparam logic [ADDR_W-1:0] A_BIOS_HI = ADDR_W'(BIOS_HI);
  localparam logic [ADDR_W-1:0] A_EXP     = ADDR_W'(EXP_BASE);
  localparam logic [ADDR_W-1:0] A_WIN_LO  = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] A_WIN_HI  = ADDR_W'(WIN_HI);

  logic [ADDR_W-1:0] ofs;

  always_comb begin
    cls       = CLS_OTHER;
    idx       = '0;
    ofs       = addr - A_EXP;
    below_tom = addr < TOP_OF_MEM;
    if (addr >= A_BIOS_LO && addr <= A_BIOS_HI) begin
      cls = CLS_ATTR;
    end else if (addr >= A_EXP && addr < A_BIOS_LO) begin
      cls = CLS_ATTR;
      idx = IDX_W'(ofs >> EXP_LOG2) + IDX_W'(1);
    end else if (addr >= A_WIN_LO && addr <= A_WIN_HI) begin
      cls = CLS_WIN;
    end
  end
endmodule

// File: rtl/lma_route_select.sv
module lma_route_select
  import lma_pkg::*;
(
  input  logic [NUM_REGIONS-1:0][1:0] fields,
  input  addr_cls_e                   cls,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        below_tom,
  input  logic                        is_write,
  input  logic                        in_smm,
  input  logic                        win_open,
  input  logic                        win_gen,
  output logic                        to_dram
);
  logic [1:0] fld;

  always_comb begin
    fld = 2'b00;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (idx == IDX_W'(r)) fld = fields[r];
    end
  end

  always_comb begin
    unique case (cls)
      CLS_ATTR: to_dram = is_write ? fld[1] : fld[0];
      CLS_WIN:  to_dram = in_smm ? win_gen : win_open;
      default:  to_dram = below_tom;
    endcase
  end
endmodule

// File: rtl/lma_out_stage.sv
module lma_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_dram,
  output logic out_valid,
  input  logic out_ready,
  output logic out_dram
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dram  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_dram <= in_dram;
    end
  end
endmodule

// File: rtl/lma_decoder.sv
module lma_decoder
  import lma_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]  TOP_OF_MEM = 'h0800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [5:0]        cfg_dw,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_smm,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_to_dram
);
  logic [NUM_REGIONS-1:0][1:0] fields;
  logic                        win_open;
  logic                        win_gen;
  addr_cls_e                   cls;
  logic [IDX_W-1:0]            idx;
  logic                        below_tom;
  logic                        route_dram;

  lma_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .fields(fields),
    .win_open(win_open), .win_gen(win_gen)
  );

  lma_region_decode #(.ADDR_W(ADDR_W), .TOP_OF_MEM(TOP_OF_MEM)) u_dec (
    .addr(req_addr), .cls(cls), .idx(idx), .below_tom(below_tom)
  );

  lma_route_select u_sel (
    .fields(fields), .cls(cls), .idx(idx), .below_tom(below_tom),
    .is_write(req_write), .in_smm(req_smm), .win_open(win_open),
    .win_gen(win_gen), .to_dram(route_dram)
  );

  lma_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_dram(route_dram), .out_valid(dec_valid), .out_ready(dec_ready),
    .out_dram(dec_to_dram)
  );
endmodule

// File: rtl/lma_decoder_chk.sv
module lma_decoder_chk #(
  parameter int unsigned        ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]  TOP_OF_MEM = 'h0800_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic              dec_to_dram
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(req_valid && req_ready) && !$past(dec_valid)) |-> !dec_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_to_dram)));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !req_ready);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> dec_valid);

  p_high_pci_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr >= TOP_OF_MEM) |=> !dec_to_dram);

  p_low_dram_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr < ADDR_W'('hA0000)) |=> dec_to_dram);
endmodule

bind lma_decoder lma_decoder_chk #(.ADDR_W(ADDR_W), .TOP_OF_MEM(TOP_OF_MEM)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .dec_valid(dec_valid), .dec_ready(dec_ready),
  .dec_to_dram(dec_to_dram)
);

// File: tb/lma_decoder_tb.sv
module lma_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOM = 32'h0800_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_smm = 1'b0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic        dec_to_dram;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_attr [7];
  logic [7:0] m_smm;

  always #(CLK_PERIOD/2) clk = ~clk;

  lma_decoder #(.ADDR_W(32), .TOP_OF_MEM(TOM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_smm(req_smm), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_to_dram(dec_to_dram)
  );

  function automatic logic exp_dram(logic [31:0] a, logic w, logic s);
    logic [3:0] nib;
    int r;
    if (a >= 32'hF0000 && a <= 32'hFFFFF) begin
      nib = m_attr[0][7:4];
      return w ? nib[1] : nib[0];
    end else if (a >= 32'hC0000 && a < 32'hF0000) begin
      r = int'((a - 32'hC0000) / 32'h4000) + 1;
      nib = (r % 2 == 1) ? m_attr[(r+1)/2][3:0] : m_attr[r/2][7:4];
      return w ? nib[1] : nib[0];
    end else if (a >= 32'hA0000 && a <= 32'hBFFFF) begin
      return s ? m_smm[3] : m_smm[6];
    end
    return a < TOM;
  endfunction

  task automatic model_write(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    for (int b = 0; b < 4; b++) begin
      int off;
      off = int'(dw) * 4 + b;
      if (be[b]) begin
        if (off >= 'h59 && off <= 'h5F) m_attr[off - 'h59] = d[8*b +: 8];
        if (off == 'h72) m_smm = d[8*b +: 8];
      end
    end
  endtask

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    model_write(dw, be, d);
  endtask

  task automatic send(logic [31:0] a, logic w, logic s, string tag);
    logic e;
    e = exp_dram(a, w, s);
    req_addr = a; req_write = w; req_smm = s; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(dec_valid, 1'b1, {tag, " valid"});
    check(dec_to_dram, e, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 7; i++) m_attr[i] = 8'h00;
    m_smm = 8'h02;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check(dec_valid, 1'b0, "R1 reset dec_valid");
    check(req_ready, 1'b1, "R10 ready when empty");

    // R1: reset routing
    send(32'hF8000, 1'b0, 1'b0, "R1 bios read pci");
    send(32'hC4000, 1'b1, 1'b0, "R1 region2 write pci");
    send(32'hA8000, 1'b0, 1'b0, "R1 window normal pci");
    send(32'hB0000, 1'b0, 1'b1, "R1 window smm pci");

    // R5 / R6: open and global enable bits separately
    cfg(6'h1C, 4'b0100, 32'h0040_0000);
    send(32'hA0000, 1'b0, 1'b0, "R5 open normal dram");
    send(32'hBFFFF, 1'b0, 1'b1, "R6 open smm pci");
    cfg(6'h1C, 4'b0100, 32'h0008_0000);
    send(32'hA0000, 1'b1, 1'b0, "R5 gen normal pci");
    send(32'hBFFFF, 1'b1, 1'b1, "R6 gen smm dram");

    // R3 / R4: byte 0x5A = 0x21 -> region1 read only, region2 write only
    cfg(6'h16, 4'b0100, 32'h0021_0000);
    send(32'hC0000, 1'b0, 1'b0, "R3 region1 read dram");
    send(32'hC3FFF, 1'b1, 1'b0, "R4 region1 write pci");
    send(32'hC4000, 1'b0, 1'b0, "R4 region2 read pci");
    send(32'hC7FFF, 1'b1, 1'b0, "R3 region2 write dram");
    send(32'hC8000, 1'b0, 1'b0, "R2 region3 boundary pci");

    // R3: region 0 uses high nibble of 0x59; region 12 high nibble of 0x5F
    cfg(6'h16, 4'b0010, 32'h0000_1000);
    send(32'hF0000, 1'b0, 1'b0, "R3 region0 read dram");
    send(32'hFFFFF, 1'b1, 1'b0, "R3 region0 write pci");
    cfg(6'h17, 4'b1000, 32'h2300_0000);
    send(32'hEC000, 1'b1, 1'b0, "R2 region12 write dram");
    send(32'hE8000, 1'b1, 1'b0, "R2 region11 write dram");

    // R8: disabled lanes and foreign offsets are dropped
    cfg(6'h16, 4'b1101, 32'hFFFF_FFFF);
    send(32'hF0000, 1'b1, 1'b0, "R8 lane disabled keeps region0");
    cfg(6'h1C, 4'b1011, 32'hFFFF_FFFF);
    send(32'hA4000, 1'b0, 1'b0, "R8 neighbour bytes ignored");
    cfg(6'h15, 4'b1111, 32'hFFFF_FFFF);
    send(32'hC0000, 1'b1, 1'b0, "R8 other dword ignored");

    // R7: outside regions
    send(32'h0009_FFFF, 1'b0, 1'b0, "R7 low dram");
    send(TOM - 1, 1'b1, 1'b0, "R7 below tom dram");
    send(TOM, 1'b0, 1'b1, "R7 at tom pci");

    // R9: write and request in same cycle use old config
    begin
      logic e_old;
      e_old = exp_dram(32'hD0000, 1'b0, 1'b0);
      cfg_wr = 1'b1; cfg_dw = 6'h17; cfg_be = 4'b0001; cfg_wdata = 32'h0000_0011;
      req_addr = 32'hD0000; req_write = 1'b0; req_smm = 1'b0; req_valid = 1'b1;
      @(posedge clk); #1;
      cfg_wr = 1'b0; req_valid = 1'b0;
      model_write(6'h17, 4'b0001, 32'h0000_0011);
      check(dec_to_dram, e_old, "R9 same-edge request sees old config");
      send(32'hD0000, 1'b0, 1'b0, "R9 next request sees new config");
    end

    // R10: back-pressure
    send(32'h0005_0000, 1'b0, 1'b0, "R10 first accepted");
    dec_ready = 1'b0;
    req_addr = TOM + 32'h100; req_write = 1'b0; req_smm = 1'b0; req_valid = 1'b1;
    #1;
    check(req_ready, 1'b0, "R10 ready low while stalled");
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      check(dec_valid, 1'b1, "R10 held valid");
      check(dec_to_dram, 1'b1, "R10 held route");
    end
    dec_ready = 1'b1;
    #1;
    check(req_ready, 1'b1, "R10 ready with consumer ready");
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(dec_to_dram, 1'b0, "R10 second after release");
    @(posedge clk); #1;
    check(dec_valid, 1'b0, "R10 drains empty");

    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 10 < 3) begin
        logic [5:0] dw;
        case ($urandom % 4)
          0: dw = 6'h16;
          1: dw = 6'h17;
          2: dw = 6'h1C;
          default: dw = 6'($urandom);
        endcase
        cfg(dw, 4'($urandom), $urandom);
      end else begin
        logic [31:0] a;
        case ($urandom % 5)
          0: a = 32'hA0000 + ($urandom % 32'h20000);
          1, 2: a = 32'hC0000 + ($urandom % 32'h40000);
          3: a = $urandom % 32'hA0000;
          default: a = $urandom;
        endcase
        send(a, 1'($urandom), 1'($urandom), "R4 R5 R6 R7 random route");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule